// File: doc/BRIEF.md
# Byte-Parity Error Monitor with Remote Error Indication

This block watches a byte stream that is split into frames and checks two interleaved even-parity codes (BIP-8). The section code covers every valid byte of a frame. The line code covers only the bytes marked as line coverage. Each code is worked out over one whole frame. It is then compared with a parity byte that arrives at a strobed position in the following frame. The mismatch between the two is turned into an error increment. In bit mode the increment is the number of disagreeing bit positions. In block mode it is one for any disagreement. Each instance sets the mode separately for the section and line codes.

The line-level increment of each frame is also presented as a remote error indication value, for insertion into the outgoing direction. A third counter adds up the remote error values found in the received REI byte position. All three counters saturate. A snapshot strobe copies their totals to the output registers and restarts the counts from zero.

Top module: `bip8_rei_monitor`

## Requirements
- R1: In bit mode (SEC_BLOCK=0), a section parity byte adds to the section count the number of bits in which it differs from the XOR of all valid bytes of the previous frame. The previous frame runs from one frame-start byte up to the byte before the next one.
- R2: In block mode (SEC_BLOCK=1 for section, LINE_BLOCK=1 for line), a mismatching parity byte adds exactly 1. A matching one adds 0.
- R3: The line parity is the XOR of only those valid bytes of the previous frame with line_cov=1. The line parity byte is compared against it and counted in the mode set by LINE_BLOCK.
- R4: A parity byte is not compared until two frame-start bytes have been seen, so that one complete frame has passed. Before that it adds nothing and raises no pulse.
- R5: rei_out takes the line increment of the frame in the cycle after the line parity byte: 0..8 in bit mode, 0 or 1 in block mode. It holds that value until the next line parity byte.
- R6: A valid byte at the REI position adds its value to the REI count when the value is 0..8. A value above 8 adds 0.
- R7: Each counter stops at 2^CW-1 instead of wrapping.
- R8: On snap, each output count register takes the counter total including that cycle's increment, and the counter restarts from 0.
- R9: err_pulse is high for exactly one cycle after a compared parity byte that mismatches. It is low otherwise.
- R10: After reset all counts, rei_out and err_pulse are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Byte valid |
| in_byte | input | 8 | Data byte |
| frame_start | input | 1 | First byte of a frame |
| line_cov | input | 1 | Byte belongs to line parity coverage |
| b1_pos | input | 1 | Byte is the section parity byte |
| b2_pos | input | 1 | Byte is the line parity byte |
| m1_pos | input | 1 | Byte carries the received REI value |
| snap | input | 1 | Snapshot and clear counters |
| sec_errs | output | CW | Last snapshot of section errors |
| line_errs | output | CW | Last snapshot of line errors |
| rei_errs | output | CW | Last snapshot of received REI total |
| rei_out | output | 4 | Outgoing REI value |
| err_pulse | output | 1 | Mismatch seen on last parity byte |

## Verification
A wrong parity accumulator or a stale reference frame shows up at once. err_pulse and rei_out are wrong in the cycle after the affected parity byte. Faults in the counters stay hidden until the next snapshot, where the totals are compared with independently computed sums. Two instances with opposite mode settings run on the same stimulus, so each mode is checked for both codes. A small counter width lets saturation be reached within a few frames.

// File: rtl/bip8_rei_monitor.sv
module bip8_rei_monitor #(
  parameter int CW = 16,
  parameter bit SEC_BLOCK = 1'b0,
  parameter bit LINE_BLOCK = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [7:0]    in_byte,
  input  logic          frame_start,
  input  logic          line_cov,
  input  logic          b1_pos,
  input  logic          b2_pos,
  input  logic          m1_pos,
  input  logic          snap,
  output logic [CW-1:0] sec_errs,
  output logic [CW-1:0] line_errs,
  output logic [CW-1:0] rei_errs,
  output logic [3:0]    rei_out,
  output logic          err_pulse
);
  logic [7:0] sec_acc, line_acc, sec_ref, line_ref;
  logic started, ref_ok;
  logic [CW-1:0] sec_run, line_run, rei_run;

  wire fs     = in_vld & frame_start;
  wire b1_hit = in_vld & b1_pos & ref_ok & ~fs;
  wire b2_hit = in_vld & b2_pos & ref_ok & ~fs;
  wire [7:0] sec_diff  = in_byte ^ sec_ref;
  wire [7:0] line_diff = in_byte ^ line_ref;

  wire [3:0] sec_amt  = SEC_BLOCK  ? {3'd0, |sec_diff}  : 4'($countones(sec_diff));
  wire [3:0] line_amt = LINE_BLOCK ? {3'd0, |line_diff} : 4'($countones(line_diff));
  wire [3:0] sec_inc  = b1_hit ? sec_amt : 4'd0;
  wire [3:0] line_inc = b2_hit ? line_amt : 4'd0;
  wire [3:0] rei_inc  = (in_vld && m1_pos && in_byte <= 8'd8) ? in_byte[3:0] : 4'd0;

  function automatic logic [CW-1:0] sat_add(input logic [CW-1:0] a, input logic [3:0] b);
    logic [CW:0] s;
    s = {1'b0, a} + {{(CW-3){1'b0}}, b};
    return s[CW] ? {CW{1'b1}} : s[CW-1:0];
  endfunction

  wire [CW-1:0] sec_nxt  = sat_add(sec_run, sec_inc);
  wire [CW-1:0] line_nxt = sat_add(line_run, line_inc);
  wire [CW-1:0] rei_nxt  = sat_add(rei_run, rei_inc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_acc <= '0; line_acc <= '0; sec_ref <= '0; line_ref <= '0;
      started <= 1'b0; ref_ok <= 1'b0;
    end else if (fs) begin
      sec_ref  <= sec_acc;
      line_ref <= line_acc;
      sec_acc  <= in_byte;
      line_acc <= line_cov ? in_byte : 8'd0;
      started  <= 1'b1;
      ref_ok   <= started;
    end else if (in_vld) begin
      sec_acc <= sec_acc ^ in_byte;
      if (line_cov) line_acc <= line_acc ^ in_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_run <= '0; line_run <= '0; rei_run <= '0;
      sec_errs <= '0; line_errs <= '0; rei_errs <= '0;
      rei_out <= '0; err_pulse <= 1'b0;
    end else begin
      if (snap) begin
        sec_errs <= sec_nxt; line_errs <= line_nxt; rei_errs <= rei_nxt;
        sec_run <= '0; line_run <= '0; rei_run <= '0;
      end else begin
        sec_run <= sec_nxt; line_run <= line_nxt; rei_run <= rei_nxt;
      end
      if (b2_hit) rei_out <= line_amt;
      err_pulse <= (b1_hit & |sec_diff) | (b2_hit & |line_diff);
    end
  end

  assert_rei_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rei_out <= (LINE_BLOCK ? 4'd1 : 4'd8));
  assert_snap_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> (sec_run == '0 && line_run == '0 && rei_run == '0));
  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> (sec_run >= $past(sec_run) && line_run >= $past(line_run) && rei_run >= $past(rei_run)));
  assert_pulse_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(b1_hit | b2_hit));
endmodule

// File: tb/tb_bip8_rei_monitor.sv
module tb_bip8_rei_monitor;
  localparam int CW = 6;
  localparam int MAXV = 63;
  logic clk = 1'b0;
  logic rst_n, in_vld, frame_start, line_cov, b1_pos, b2_pos, m1_pos, snap;
  logic [7:0] in_byte;
  logic [CW-1:0] s0, l0, r0, s1, l1, r1;
  logic [3:0] ro0, ro1;
  logic ep0, ep1;
  int tests = 0, fails = 0;
  int es0 = 0, el0 = 0, es1 = 0, el1 = 0, er = 0;
  int nfs = 0;
  logic [7:0] sec_prev = 8'd0, line_prev = 8'd0, cur_sec, cur_line;

  always #4 clk = ~clk;

  bip8_rei_monitor #(.CW(CW), .SEC_BLOCK(1'b0), .LINE_BLOCK(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_byte(in_byte), .frame_start(frame_start),
    .line_cov(line_cov), .b1_pos(b1_pos), .b2_pos(b2_pos), .m1_pos(m1_pos), .snap(snap),
    .sec_errs(s0), .line_errs(l0), .rei_errs(r0), .rei_out(ro0), .err_pulse(ep0));
  bip8_rei_monitor #(.CW(CW), .SEC_BLOCK(1'b1), .LINE_BLOCK(1'b0)) dut2 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_byte(in_byte), .frame_start(frame_start),
    .line_cov(line_cov), .b1_pos(b1_pos), .b2_pos(b2_pos), .m1_pos(m1_pos), .snap(snap),
    .sec_errs(s1), .line_errs(l1), .rei_errs(r1), .rei_out(ro1), .err_pulse(ep1));

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: run hung, actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return v > MAXV ? MAXV : v;
  endfunction

  task automatic send(input logic [7:0] b, input logic f, input logic lc,
                      input logic p1, input logic p2, input logic pm);
    @(negedge clk);
    in_vld = 1'b1; in_byte = b; frame_start = f; line_cov = lc;
    b1_pos = p1; b2_pos = p2; m1_pos = pm;
    @(posedge clk); #1;
    in_vld = 1'b0; frame_start = 1'b0; b1_pos = 1'b0; b2_pos = 1'b0; m1_pos = 1'b0;
  endtask

  // Frame: start, section parity, line parity, REI byte, four payload bytes.
  task automatic frame(input logic [7:0] e1, input logic [7:0] e2, input logic [7:0] m1v,
                       input logic [7:0] seed);
    logic [7:0] b;
    bit cmp;
    nfs++;
    cmp = (nfs >= 2);
    cur_sec = 8'd0; cur_line = 8'd0;
    b = seed; send(b, 1, 0, 0, 0, 0); cur_sec ^= b;
    b = sec_prev ^ e1; send(b, 0, 0, 1, 0, 0); cur_sec ^= b;
    chk("R9 pulse after section byte", ep0, int'(cmp && e1 != 0));
    if (cmp) begin
      es0 = sat(es0 + $countones(e1));
      es1 = sat(es1 + int'(e1 != 0));
    end
    b = line_prev ^ e2; send(b, 0, 1, 0, 1, 0); cur_sec ^= b; cur_line ^= b;
    chk("R9 pulse after line byte", ep1, int'(cmp && e2 != 0));
    if (cmp) begin
      el0 = sat(el0 + int'(e2 != 0));
      el1 = sat(el1 + $countones(e2));
      chk("R5 rei_out block mode", ro0, int'(e2 != 0));
      chk("R5 rei_out bit mode", ro1, $countones(e2));
    end
    send(m1v, 0, 1, 0, 0, 1); cur_sec ^= m1v; cur_line ^= m1v;
    er = sat(er + (m1v <= 8 ? int'(m1v) : 0));
    for (int i = 0; i < 4; i++) begin
      b = seed * 8'd7 + 8'(i * 29);
      send(b, 0, (i != 1), 0, 0, 0);
      cur_sec ^= b;
      if (i != 1) cur_line ^= b;
    end
    chk("R9 no pulse on payload", ep0 | ep1, 0);
    sec_prev = cur_sec; line_prev = cur_line;
  endtask

  task automatic snapshot(input string req);
    @(negedge clk); snap = 1'b1;
    @(posedge clk); #1; snap = 1'b0;
    chk({req, " bit-mode section"}, s0, es0);
    chk({req, " block-mode line"}, l0, el0);
    chk({req, " block-mode section"}, s1, es1);
    chk({req, " bit-mode line"}, l1, el1);
    chk({req, " rei total"}, r0, er);
    chk({req, " rei total dut2"}, r1, er);
    es0 = 0; el0 = 0; es1 = 0; el1 = 0; er = 0;
  endtask

  task automatic t_reset;
    chk("R10 counts zero", int'(s0) + int'(l0) + int'(r0) + int'(s1) + int'(l1) + int'(r1), 0);
    chk("R10 rei_out zero", int'(ro0) + int'(ro1), 0);
    chk("R10 pulse zero", int'(ep0) + int'(ep1), 0);
  endtask

  task automatic t_first_frames;
    frame(8'hFF, 8'h0F, 8'd3, 8'h11);
    snapshot("R4 first frame ignored, R6 rei counted");
  endtask

  task automatic t_modes;
    frame(8'h05, 8'h00, 8'd0, 8'h22);
    frame(8'h00, 8'h81, 8'd2, 8'h35);
    frame(8'h00, 8'h00, 8'd0, 8'h47);
    snapshot("R1 R2 R3 error counts");
    snapshot("R8 clear after snap");
  endtask

  task automatic t_rei_range;
    frame(8'h00, 8'h00, 8'd9, 8'h50);
    frame(8'h00, 8'h00, 8'd8, 8'h61);
    frame(8'h00, 8'h00, 8'd200, 8'h72);
    snapshot("R6 rei range");
  endtask

  task automatic t_saturate;
    for (int k = 0; k < 9; k++) frame(8'hFF, 8'hFF, 8'd8, 8'(k + 3));
    snapshot("R7 saturation");
  endtask

  initial begin
    rst_n = 1'b0; in_vld = 1'b0; in_byte = 8'd0; frame_start = 1'b0; line_cov = 1'b0;
    b1_pos = 1'b0; b2_pos = 1'b0; m1_pos = 1'b0; snap = 1'b0;
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1;
    t_reset();
    t_first_frames();
    t_modes();
    t_rei_range();
    t_saturate();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule